// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in the transmit path of a network controller. It collects an outgoing frame byte by byte into a local buffer until the byte flagged as final arrives. A per-frame control header, loaded in one wide transfer, can ask for a checksum. In that case the engine sums the frame as 16-bit ones-complement words from a chosen start offset to the end, adds a seed, folds and inverts the result, and writes it into the buffered frame at a chosen offset with the high byte first. It then streams the finished frame out and pulses a completion flag.

A small configuration word controls the engine. It holds a transmit-enable bit, two size-policy bits (oversize allowance and tagged-frame allowance) and a self-clearing transmit-reset bit. Frames that do not fit in the buffer, frames in the forbidden size window, and all traffic while transmit is off are consumed and never sent.

Top module: `tx_csum_offload`

## Requirements
- R1: After reset `s_ready` is 1, `m_valid` and `tx_done` are 0, and the configuration has transmit, oversize and tagged-frame allowances all on, so a 1520-byte frame is sent without any configuration write.
- R2: With header word 0 bit 0 clear, a frame is sent unchanged and in order, with `m_last` on its final byte. Input is refused (`s_ready` low) from the final input byte until the frame has left.
- R3: The header is five 32-bit words, word k on `hdr_words[32k+31:32k]`. Word 0 bit 0 enables insertion. Word 1 bits 31:16 hold the start offset and bits 15:0 the write offset. Word 2 bits 15:0 hold the seed. When insertion is enabled, the byte at the write offset becomes bits 15:8 of the inverted folded sum and the next byte becomes bits 7:0. The header must be loaded while `s_ready` is high and before the frame's first byte.
- R4: The sum pairs bytes from the start offset as big-endian words and pads a trailing odd byte with zero in the low half. It adds the seed and folds the end-around carry twice. A start offset at or beyond the frame end yields the inverted folded seed.
- R5: A frame longer than `DEPTH` bytes is consumed and dropped. No byte and no `tx_done` appear for it, and the next frame is handled normally. A frame of exactly `DEPTH` bytes is sent.
- R6: While configuration bit 28 (transmit enable) is clear, input bytes are accepted and discarded.
- R7: When bit 30 (oversize allowance) and bit 27 (tagged allowance) are both clear, frames of 1519 to 1522 bytes are dropped, and frames of 1518 and 1523 bytes are sent. With bit 27 set, a 1520-byte frame is sent.
- R8: A configuration write with bit 31 set restores bits 27, 28 and 30 to 1 and abandons any partial or pending frame. An input byte accepted in the same cycle is discarded.
- R9: `tx_done` is high for exactly one cycle, in the cycle after the final output byte is accepted. While `m_valid` is high and `m_ready` low, `m_valid` stays high and `m_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (bits 27, 28, 30, 31 used) |
| hdr_load | input | 1 | Header load strobe |
| hdr_words | input | 160 | Five header words, word k at bits 32k+31:32k |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Input byte is the final byte of the frame |
| s_ready | output | 1 | Engine accepts an input byte |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Output byte is the final byte of the frame |
| m_ready | input | 1 | Downstream accepts an output byte |
| tx_done | output | 1 | One-cycle pulse when a frame has been sent |

## Verification
A transmit-reset write and an incoming data byte can land on the same clock edge. The reset must win: the byte and the partial frame are lost, and the size policy returns to its permissive default. The bench provokes this by raising the configuration strobe with bit 31 in the very cycle it presents a byte, after it has cleared both size allowances and sent part of a frame. It then sends a 1520-byte frame and judges the outcome by whether exactly that frame comes out, byte for byte, with nothing from the abandoned fragment ahead of it. Random downstream back-pressure runs throughout, so holding, completion timing and checksum placement are judged under stalls.

// File: rtl/ckoff_pkg.sv
// Shared definitions for the transmit checksum insertion engine.
// Assumes configuration bit positions are fixed by software convention.
package ckoff_pkg;

    typedef enum logic [1:0] {
        ST_RECV   = 2'd0,
        ST_FIX_HI = 2'd1,
        ST_FIX_LO = 2'd2,
        ST_SEND   = 2'd3
    } ckoff_state_t;

    localparam int CFG_VLAN_BIT  = 27;
    localparam int CFG_TXEN_BIT  = 28;
    localparam int CFG_JUMBO_BIT = 30;
    localparam int CFG_RESET_BIT = 31;

    localparam int STD_MAX_LEN    = 1518;
    localparam int TAGGED_MAX_LEN = 1522;

    // Fold a partial sum twice into 16 bits and invert it.
    function automatic logic [15:0] fold_complement(input logic [31:0] s);
        logic [16:0] f1;
        logic [16:0] f2;
        f1 = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        f2 = {1'b0, f1[15:0]} + {16'b0, f1[16]};
        return ~f2[15:0];
    endfunction

endpackage

// File: rtl/ckoff_cfg.sv
// Transmit configuration flags. A write with the reset bit restores the
// permissive defaults; otherwise the flags follow the written word.
// Assumes writes are single-cycle strobes.
module ckoff_cfg
    import ckoff_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic        tx_en,
    output logic        jumbo_en,
    output logic        vlan_en,
    output logic        soft_rst
);

    logic [2:0] flags_q;   // {jumbo, tx, vlan}
    logic       unused_cfg_bits;

    assign unused_cfg_bits = ^{wdata[29], wdata[26:0]};
    assign soft_rst = wr_en & wdata[CFG_RESET_BIT];

    // Hold the three policy flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 3'b111;
        end else if (wr_en) begin
            if (wdata[CFG_RESET_BIT]) begin
                flags_q <= 3'b111;
            end else begin
                flags_q <= {wdata[CFG_JUMBO_BIT], wdata[CFG_TXEN_BIT], wdata[CFG_VLAN_BIT]};
            end
        end
    end

    assign jumbo_en = flags_q[2];
    assign tx_en    = flags_q[1];
    assign vlan_en  = flags_q[0];

endmodule

// File: rtl/ckoff_sum.sv
// Running ones-complement accumulator. Bytes at or past the start offset
// are added as the high or low half of a big-endian word by their parity
// relative to the start. Assumes PW <= 16 and SUM_W <= 32.
module ckoff_sum #(
    parameter int PW    = 12,
    parameter int SUM_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             first,
    input  logic [PW-1:0]    idx,
    input  logic [15:0]      start,
    input  logic [7:0]       byte_in,
    output logic [SUM_W-1:0] acc
);

    logic [16:0] idx_x;
    logic        in_range;
    logic        low_half;
    logic [15:0] contrib;

    assign idx_x    = 17'(idx);
    assign in_range = idx_x >= {1'b0, start};
    assign low_half = idx[0] ^ start[0];
    assign contrib  = !in_range ? 16'h0000 :
                      (low_half ? {8'h00, byte_in} : {byte_in, 8'h00});

    // Accumulate one byte per accepted beat; restart on a frame's first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= (first ? '0 : acc) + SUM_W'(contrib);
        end
    end

endmodule

// File: rtl/ckoff_buf.sv
// Frame store: one write port, asynchronous read port.
// Assumes the reader never addresses a byte in the cycle it is written.
module ckoff_buf #(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    // Store one byte per cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tx_csum_offload.sv
// Transmit checksum insertion engine. Buffers a frame, optionally folds a
// ones-complement checksum into it at a header-given offset, then streams
// it out. Assumes the header is loaded between frames and DEPTH <= 32768.
module tx_csum_offload
    import ckoff_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [31:0]  cfg_wdata,
    input  logic         hdr_load,
    input  logic [159:0] hdr_words,
    input  logic         s_valid,
    input  logic [7:0]   s_data,
    input  logic         s_last,
    output logic         s_ready,
    output logic         m_valid,
    output logic [7:0]   m_data,
    output logic         m_last,
    input  logic         m_ready,
    output logic         tx_done
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PW     = ADDR_W + 1;
    localparam int SUM_W  = ADDR_W + 17;

    ckoff_state_t      state_q;
    logic [PW-1:0]     pos_q;
    logic [PW-1:0]     len_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic              discard_q;
    logic              done_q;

    logic              hdr_en_q;
    logic [15:0]       hdr_start_q;
    logic [ADDR_W-1:0] hdr_woff_q;
    logic [15:0]       hdr_seed_q;

    logic              tx_en, jumbo_en, vlan_en, soft_rst;
    logic              beat, keep, full;
    logic [PW-1:0]     frame_len;
    logic [31:0]       len32;
    logic              size_bad;
    logic [SUM_W-1:0]  acc;
    logic [15:0]       csum;
    logic              buf_we;
    logic [ADDR_W-1:0] buf_waddr;
    logic [7:0]        buf_wdata;
    logic [7:0]        rd_byte;
    logic              unused_hdr_bits;

    assign unused_hdr_bits = ^{hdr_words[159:80], hdr_words[47:32+ADDR_W], hdr_words[31:1]};

    ckoff_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wdata    (cfg_wdata),
        .tx_en    (tx_en),
        .jumbo_en (jumbo_en),
        .vlan_en  (vlan_en),
        .soft_rst (soft_rst)
    );

    assign s_ready   = (state_q == ST_RECV);
    assign beat      = s_valid && s_ready;
    assign full      = (pos_q == PW'(DEPTH));
    assign keep      = beat && tx_en && !discard_q && !full && !soft_rst;
    assign frame_len = pos_q + PW'(1);
    assign len32     = 32'(frame_len);
    assign size_bad  = !jumbo_en && !vlan_en &&
                       (len32 > STD_MAX_LEN) && (len32 <= TAGGED_MAX_LEN);

    ckoff_sum #(.PW(PW), .SUM_W(SUM_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (keep),
        .first   (pos_q == '0),
        .idx     (pos_q),
        .start   (hdr_start_q),
        .byte_in (s_data),
        .acc     (acc)
    );

    assign csum = fold_complement(32'(acc) + {16'h0000, hdr_seed_q});

    // Select what the single buffer write port stores this cycle.
    always_comb begin
        buf_we    = 1'b0;
        buf_waddr = pos_q[ADDR_W-1:0];
        buf_wdata = s_data;
        unique case (state_q)
            ST_RECV:   buf_we = keep;
            ST_FIX_HI: begin
                buf_we    = 1'b1;
                buf_waddr = hdr_woff_q;
                buf_wdata = csum[15:8];
            end
            ST_FIX_LO: begin
                buf_we    = 1'b1;
                buf_waddr = hdr_woff_q + ADDR_W'(1);
                buf_wdata = csum[7:0];
            end
            default:   buf_we = 1'b0;
        endcase
    end

    ckoff_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (rd_ptr_q),
        .rdata (rd_byte)
    );

    // Capture the per-frame header fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_en_q    <= 1'b0;
            hdr_start_q <= '0;
            hdr_woff_q  <= '0;
            hdr_seed_q  <= '0;
        end else if (hdr_load) begin
            hdr_en_q    <= hdr_words[0];
            hdr_start_q <= hdr_words[63:48];
            hdr_woff_q  <= hdr_words[32 +: ADDR_W];
            hdr_seed_q  <= hdr_words[79:64];
        end
    end

    // Frame sequencing: collect, patch, send; soft reset overrides all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RECV;
            pos_q     <= '0;
            len_q     <= '0;
            rd_ptr_q  <= '0;
            discard_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (soft_rst) begin
                state_q   <= ST_RECV;
                pos_q     <= '0;
                rd_ptr_q  <= '0;
                discard_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_RECV: begin
                        if (beat) begin
                            if (!tx_en) begin
                                pos_q     <= '0;
                                discard_q <= 1'b0;
                            end else if (discard_q || full) begin
                                pos_q     <= '0;
                                discard_q <= !s_last;
                            end else if (s_last) begin
                                pos_q <= '0;
                                if (!size_bad) begin
                                    len_q    <= frame_len;
                                    rd_ptr_q <= '0;
                                    state_q  <= hdr_en_q ? ST_FIX_HI : ST_SEND;
                                end
                            end else begin
                                pos_q <= pos_q + PW'(1);
                            end
                        end
                    end
                    ST_FIX_HI: state_q <= ST_FIX_LO;
                    ST_FIX_LO: state_q <= ST_SEND;
                    default: begin
                        if (m_ready) begin
                            rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
                            if (m_last) begin
                                state_q <= ST_RECV;
                                done_q  <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign m_valid = (state_q == ST_SEND);
    assign m_data  = rd_byte;
    assign m_last  = m_valid && ({1'b0, rd_ptr_q} == len_q - PW'(1));
    assign tx_done = done_q;

endmodule

// File: rtl/ckoff_checker.sv
// Temporal checks on the engine's ports, attached by bind.
// Assumes synchronous active-low reset.
module ckoff_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst_req,
    input logic       s_ready,
    input logic       m_valid,
    input logic [7:0] m_data,
    input logic       m_last,
    input logic       m_ready,
    input logic       tx_done
);

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !soft_rst_req) |=> (m_valid && $stable(m_data))); // R9

    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(m_valid && m_ready && m_last)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done); // R9

    AST_NO_INPUT_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready); // R2

    AST_SOFT_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |=> (s_ready && !m_valid)); // R8

endmodule

bind tx_csum_offload ckoff_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_req (cfg_wr & cfg_wdata[31]),
    .s_ready      (s_ready),
    .m_valid      (m_valid),
    .m_data       (m_data),
    .m_last       (m_last),
    .m_ready      (m_ready),
    .tx_done      (tx_done)
);

// File: tb/tx_csum_offload_bench.sv
module tx_csum_offload_bench;

    localparam int DEPTH = 2048;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [31:0]  cfg_wdata = '0;
    logic         hdr_load = 1'b0;
    logic [159:0] hdr_words = '0;
    logic         s_valid = 1'b0;
    logic [7:0]   s_data = '0;
    logic         s_last = 1'b0;
    logic         s_ready;
    logic         m_valid;
    logic [7:0]   m_data;
    logic         m_last;
    logic         m_ready = 1'b1;
    logic         tx_done;

    tx_csum_offload #(.DEPTH(DEPTH)) u_tx_csum_offload (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .hdr_load(hdr_load), .hdr_words(hdr_words),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready),
        .tx_done(tx_done)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    bit finished = 0;
    string cur_req = "R2";

    logic [7:0] cur[$];
    logic [7:0] exp_q[$];
    int         exp_len_q[$];

    bit m_tx = 1, m_jumbo = 1, m_vlan = 1;
    bit h_en = 0;
    int h_start = 0, h_woff = 0, h_seed = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Expected checksum over cur[] per R3/R4.
    function automatic int model_csum();
        int sum = 0;
        for (int i = h_start; i < cur.size(); i++) begin
            if (((i - h_start) % 2) == 0) sum += int'(cur[i]) << 8;
            else sum += int'(cur[i]);
        end
        sum += h_seed;
        sum = (sum & 16'hFFFF) + (sum >>> 16);
        sum = (sum & 16'hFFFF) + (sum >>> 16);
        return (~sum) & 16'hFFFF;
    endfunction

    task automatic expect_cur();
        int len = cur.size();
        int c;
        if (!m_tx) return;
        if (len > DEPTH) return;
        if (!m_jumbo && !m_vlan && len >= 1519 && len <= 1522) return;
        if (h_en) begin
            c = model_csum();
            if (h_woff < len)     cur[h_woff]     = 8'(c >> 8);
            if (h_woff + 1 < len) cur[h_woff + 1] = 8'(c);
        end
        foreach (cur[i]) exp_q.push_back(cur[i]);
        exp_len_q.push_back(len);
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        if (v[31]) begin m_tx = 1; m_jumbo = 1; m_vlan = 1; end
        else begin m_tx = v[28]; m_jumbo = v[30]; m_vlan = v[27]; end
    endtask

    task automatic load_hdr(input bit en, input int start, input int woff, input int seed);
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        hdr_load = 1'b1;
        hdr_words = {64'h0, 16'h0, 16'(seed), 16'(start), 16'(woff), 31'h0, en};
        @(posedge clk); #1;
        hdr_load = 1'b0;
        h_en = en; h_start = start; h_woff = woff; h_seed = seed;
    endtask

    task automatic push_bytes(input int n, input bit with_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = cur[i]; s_last = with_last && (i == n - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic fill_random(input int len);
        cur.delete();
        for (int i = 0; i < len; i++) cur.push_back(8'($urandom));
    endtask

    task automatic wait_idle();
        int guard = 0;
        while ((exp_q.size() != 0 || !s_ready) && guard < 4 * DEPTH + 20) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Send cur[] as one frame and wait for it to drain.
    task automatic run_frame(input string req);
        logic [7:0] sent[$];
        sent = cur;
        cur_req = req;
        expect_cur();
        cur = sent;
        push_bytes(cur.size(), 1'b1);
        wait_idle();
        check(exp_q.size() == 0, req, "expected bytes left over", exp_q.size(), 0);
    endtask

    // Downstream back-pressure.
    initial begin
        forever begin
            @(posedge clk); #1;
            m_ready = ($urandom % 4) != 0;
        end
    end

    // Output collector and protocol checks.
    initial begin
        bit prev_stall = 0, prev_last = 0, frame_bad = 0;
        logic [7:0] prev_data = '0;
        logic [7:0] b;
        int rem = 0;
        int bad_pos = -1;
        int bad_act = 0, bad_exp = 0;
        int pos = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (prev_stall)
                check(m_valid && (m_data == prev_data), "R9", "stalled byte not held",
                      int'(m_data), int'(prev_data));
            if (prev_last || tx_done)
                check(tx_done == prev_last, "R9", "tx_done timing", int'(tx_done), int'(prev_last));
            if (tx_done) done_cnt++;
            prev_stall = m_valid && !m_ready && !(cfg_wr && cfg_wdata[31]);
            prev_data  = m_data;
            prev_last  = m_valid && m_ready && m_last;
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, cur_req, "unexpected output byte", int'(m_data), -1);
                end else begin
                    b = exp_q.pop_front();
                    if (rem == 0) begin rem = exp_len_q.pop_front(); pos = 0; end
                    rem--;
                    if (b != m_data && bad_pos < 0) begin
                        frame_bad = 1; bad_pos = pos; bad_act = m_data; bad_exp = b;
                    end
                    if (m_last != (rem == 0) && bad_pos < 0) begin
                        frame_bad = 1; bad_pos = pos; bad_act = m_last; bad_exp = (rem == 0);
                    end
                    pos++;
                    if (rem == 0 || m_last) begin
                        check(!frame_bad, cur_req, $sformatf("frame content at byte %0d", bad_pos),
                              bad_act, bad_exp);
                        frame_bad = 0; bad_pos = -1;
                        while (rem > 0) begin void'(exp_q.pop_front()); rem--; end
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int d0, len, st, wo;
        void'($urandom(32'h5EED_0C5A));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(s_ready == 1'b1, "R1", "s_ready after reset", int'(s_ready), 1);
        check(m_valid == 1'b0, "R1", "m_valid after reset", int'(m_valid), 0);
        check(tx_done == 1'b0, "R1", "tx_done after reset", int'(tx_done), 0);

        // R1: default allowances let a 1520-byte frame through
        load_hdr(0, 0, 0, 0);
        fill_random(1520); d0 = done_cnt;
        run_frame("R1");
        check(done_cnt == d0 + 1, "R1", "default config frame sent", done_cnt - d0, 1);

        // R2: plain frames
        for (int k = 0; k < 5; k++) begin
            load_hdr(0, 0, 0, 0);
            fill_random(1 + $urandom_range(0, 90));
            run_frame("R2");
        end

        // R3: random checksum frames
        for (int k = 0; k < 16; k++) begin
            len = $urandom_range(14, 150);
            st  = $urandom_range(0, len - 1);
            wo  = $urandom_range(0, len - 2);
            load_hdr(1, st, wo, $urandom_range(0, 65535));
            fill_random(len);
            run_frame("R3");
        end

        // R4: odd tail, by hand 12 34 56 00 01 -> 96 CB at offset 3
        load_hdr(1, 0, 3, 0);
        cur = '{8'h12, 8'h34, 8'h56, 8'h00, 8'h01};
        run_frame("R4");
        // R4: carry folded twice (FF FF + seed FFFF)
        load_hdr(1, 0, 2, 16'hFFFF);
        cur = '{8'hFF, 8'hFF, 8'h00, 8'h00};
        run_frame("R4");
        // R4: start past end gives inverted seed
        load_hdr(1, 40, 4, 16'h1234);
        fill_random(21);
        run_frame("R4");

        // R7: size window with both allowances off
        cfg_write(32'h1000_0000);
        load_hdr(0, 0, 0, 0);
        fill_random(1518); run_frame("R7");
        d0 = done_cnt;
        fill_random(1519); run_frame("R7");
        fill_random(1522); run_frame("R7");
        check(done_cnt == d0, "R7", "1519/1522 byte frames dropped", done_cnt - d0, 0);
        fill_random(1523); run_frame("R7");
        cfg_write(32'h1800_0000);
        d0 = done_cnt;
        fill_random(1520); run_frame("R7");
        check(done_cnt == d0 + 1, "R7", "tagged allowance passes 1520", done_cnt - d0, 1);

        // R6: transmit disabled
        cfg_write(32'h4800_0000);
        d0 = done_cnt;
        fill_random(60); run_frame("R6");
        check(done_cnt == d0, "R6", "no frame while disabled", done_cnt - d0, 0);
        check(s_ready == 1'b1, "R6", "input still accepted", int'(s_ready), 1);
        cfg_write(32'h5800_0000);
        fill_random(33); run_frame("R6");

        // R5: overflow and exact fit
        d0 = done_cnt;
        fill_random(DEPTH + 5); run_frame("R5");
        check(done_cnt == d0, "R5", "oversized frame dropped", done_cnt - d0, 0);
        fill_random(DEPTH); run_frame("R5");
        check(done_cnt == d0 + 1, "R5", "exact-fit frame sent", done_cnt - d0, 1);
        fill_random(17); run_frame("R5");

        // R8: soft reset coincident with a data byte
        cfg_write(32'h1000_0000);
        load_hdr(0, 0, 0, 0);
        fill_random(10);
        push_bytes(10, 1'b0);
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'hA5; s_last = 1'b1;
        cfg_wr = 1'b1; cfg_wdata = 32'h8000_0000;
        @(posedge clk); #1;
        s_valid = 1'b0; s_last = 1'b0; cfg_wr = 1'b0;
        m_tx = 1; m_jumbo = 1; m_vlan = 1;
        @(negedge clk);
        check(s_ready == 1'b1 && m_valid == 1'b0, "R8", "idle after soft reset",
              int'(m_valid), 0);
        d0 = done_cnt;
        fill_random(1520); run_frame("R8");
        check(done_cnt == d0 + 1, "R8", "defaults restored, one frame out", done_cnt - d0, 1);

        finish_run();
    end

endmodule